// File: doc/BRIEF.md
# 22 kHz Tone Source Selector

This block produces the logic-level tone enable that a downstream output stage turns into a 22 kHz ripple on a supply line. The tone can come from an internal divider that derives a 50 % square wave from the system clock, or from an external modulation input. A small set of control bits picks the source. When that control path is disabled, the block decides by itself whether the external input is a slow envelope or an actual tone burst.

The external input passes through a two-flop synchroniser before any decision is made. An activity detector watches the synchronised level. Any edge within the last three tone half-periods marks the input as a burst, and a burst is passed straight through to the output. A level that has been steady for longer than that is treated as an envelope, and it gates the internal tone. Every internal tone run starts with a fresh full high half-period. When the run is stopped, it always ends on a completed high half-period, so no pulse is ever cut short.

With control enabled, three cases exist. The external tone can be passed through under a gate bit. The internal tone can follow the gate bit alone. Or, once the external input has risen while internal mode and the gate are set, the external input becomes an envelope for the internal tone.

Top module: `tone_source_sel`

## Requirements
- R1: While reset is high, and on the first cycle after it, `tone_out` is 0. The output is a registered signal.
- R2: The internal tone half-period is HALF = round(CLK_HZ / (2·TONE_HZ)) clock cycles, and high and low halves have equal length. The resulting frequency lies in 20–24 kHz and the duty cycle in 45–55 %.
- R3: Each time the internal tone starts from idle, its first high half lasts a full HALF cycles. It begins on the clock edge at which the start request is first seen.
- R4: When the request for the internal tone is withdrawn, the tone continues until the end of the next completed high half-period and then stays low. The last pulse is never truncated.
- R5: With `reg_ctl_en`=0, a `mod_in` level held steady for more than 3·HALF cycles is an envelope. While that envelope is high, the internal tone is output, starting on the edge after the timeout.
- R6: With `reg_ctl_en`=0, while `mod_in` has changed within the last 3·HALF cycles, `tone_out` copies `mod_in` with a latency of 3 clock edges: two synchroniser flops plus the output register.
- R7: With `reg_ctl_en`=1 and `int_sel`=0, `tone_out` copies `mod_in` (same 3-edge latency) only while `gate_en`=1. With `gate_en`=0, `tone_out` is 0 one edge later and ignores `mod_in`.
- R8: With `reg_ctl_en`=1, `int_sel`=1 and no envelope armed, the internal tone runs while `gate_en`=1, whatever `mod_in` does.
- R9: With `reg_ctl_en`=1, `int_sel`=1 and `gate_en`=1, a rising `mod_in` arms envelope mode. From then on, the internal tone runs only while `mod_in` is high. Clearing `gate_en`, `int_sel` or `reg_ctl_en` disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_in | input | 1 | Asynchronous external modulation input (envelope or tone burst) |
| reg_ctl_en | input | 1 | Control-register path enable; 0 selects automatic envelope/burst classification |
| int_sel | input | 1 | With control enabled: 1 selects the internal divider, 0 selects the external tone |
| gate_en | input | 1 | Tone gate bit for the control-enabled modes |
| tone_out | output | 1 | Registered tone enable |

## Verification
The external input is driven in three ways. A burst toggling every half-period must appear as a pure 3-edge-delayed copy. A level held high longer than the timeout must switch from pass-through to the internal tone exactly at the timeout. A level that rises after an internal run has started must arm envelope mode, and its fall must then stop the tone where the plain gate mode would keep it running. Gate withdrawal is placed inside a low half, and the check looks for exactly one more full high half. The last run measures the period and duty cycle against the frequency and duty limits.

// File: rtl/tone_sel_pkg.sv
package tone_sel_pkg;

  typedef enum logic [0:0] {
    SRC_INTERNAL = 1'b0,
    SRC_EXTERNAL = 1'b1
  } tone_src_e;

  // Rounded number of clock cycles in one tone half-period.
  function automatic int unsigned half_period_cycles(input int unsigned clk_hz,
                                                     input int unsigned tone_hz);
    return (clk_hz + tone_hz) / (2 * tone_hz);
  endfunction

endpackage

// File: rtl/tone_sync2.sv
module tone_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/tone_divider.sv
module tone_divider #(
  parameter int HALF = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic phase,
  output logic last_hi
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          ph;

  // Idle holds the phase at the start of a high half so each run begins fresh.
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      cnt <= '0;
      ph  <= 1'b1;
    end else if (cnt == WRAP) begin
      cnt <= '0;
      ph  <= ~ph;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign phase   = ph;
  assign last_hi = ph && (cnt == WRAP);

  AST_WRAP_TOGGLES: assert property (@(posedge clk) disable iff (rst) (active && cnt == WRAP) |=> (ph != $past(ph))) else $error("phase did not toggle at wrap"); // R2
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst) !active |=> (cnt == '0 && ph)) else $error("divider not restarted while idle"); // R3
  AST_MID_HALF_STABLE: assert property (@(posedge clk) disable iff (rst) (active && cnt != WRAP) |=> $stable(ph)) else $error("phase moved mid half-period"); // R2
endmodule

// File: rtl/mod_activity.sv
module mod_activity #(
  parameter int LIMIT = 180
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic recent_edge,
  output logic rise
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic          prev;
  logic [CW-1:0] quiet;
  logic          edge_now;

  assign edge_now = (lvl != prev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= 1'b0;
      quiet <= LIM;
    end else begin
      prev <= lvl;
      if (edge_now)         quiet <= '0;
      else if (quiet != LIM) quiet <= quiet + 1'b1;
    end
  end

  assign recent_edge = edge_now || (quiet != LIM);
  assign rise        = lvl && !prev;

  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (rst) edge_now |=> (quiet == '0)) else $error("edge did not clear quiet count"); // R6
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst) (quiet == LIM && !edge_now) |=> (quiet == LIM)) else $error("saturated quiet count moved"); // R5
endmodule

// File: rtl/tone_mode_ctrl.sv
module tone_mode_ctrl
  import tone_sel_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      reg_ctl_en,
  input  logic      int_sel,
  input  logic      gate_en,
  input  logic      mod_lvl,
  input  logic      mod_rise,
  input  logic      mod_recent,
  input  logic      last_hi,
  output tone_src_e src,
  output logic      ext_level,
  output logic      active
);
  logic int_mode;
  logic armed;
  logic req;
  logic run;

  assign int_mode = reg_ctl_en && int_sel && gate_en;

  // Envelope mode arms on a rising input while the internal gated mode is set.
  always_ff @(posedge clk) begin
    if (rst || !int_mode) armed <= 1'b0;
    else if (mod_rise)    armed <= 1'b1;
  end

  always_comb begin
    if (!reg_ctl_en)  req = mod_lvl && !mod_recent;
    else if (int_sel) req = gate_en && (armed ? mod_lvl : 1'b1);
    else              req = 1'b0;
  end

  // Run keeps the divider going after the request drops until a high half ends.
  always_ff @(posedge clk) begin
    if (rst)          run <= 1'b0;
    else if (req)     run <= 1'b1;
    else if (last_hi) run <= 1'b0;
  end

  assign active    = run || req;
  assign src       = ((!reg_ctl_en && mod_recent) || (reg_ctl_en && !int_sel)) ? SRC_EXTERNAL : SRC_INTERNAL;
  assign ext_level = mod_lvl && (reg_ctl_en ? gate_en : 1'b1);

  AST_DRAIN_KEEPS_RUN: assert property (@(posedge clk) disable iff (rst) (run && !req && !last_hi) |=> run) else $error("tone stopped before a high half ended"); // R4
  AST_STOP_ON_HIGH: assert property (@(posedge clk) disable iff (rst) $fell(run) |-> $past(last_hi)) else $error("run fell outside a high-half end"); // R4
  AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (rst) (int_mode && mod_rise) |=> armed) else $error("envelope mode not armed"); // R9
endmodule

// File: rtl/tone_source_sel.sv
module tone_source_sel
  import tone_sel_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned TONE_HZ = 22_000
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_in,
  input  logic reg_ctl_en,
  input  logic int_sel,
  input  logic gate_en,
  output logic tone_out
);
  localparam int HALF      = int'(half_period_cycles(CLK_HZ, TONE_HZ));
  localparam int ENV_LIMIT = 3 * HALF;

  logic      mod_s;
  logic      mod_recent;
  logic      mod_rise;
  logic      phase;
  logic      last_hi;
  logic      active;
  logic      ext_level;
  tone_src_e src;

  tone_sync2 #(.STAGES(2)) u_sync (
    .clk (clk), .rst (rst), .d (mod_in), .q (mod_s)
  );

  mod_activity #(.LIMIT(ENV_LIMIT)) u_act (
    .clk (clk), .rst (rst), .lvl (mod_s),
    .recent_edge (mod_recent), .rise (mod_rise)
  );

  tone_divider #(.HALF(HALF)) u_div (
    .clk (clk), .rst (rst), .active (active),
    .phase (phase), .last_hi (last_hi)
  );

  tone_mode_ctrl u_ctrl (
    .clk (clk), .rst (rst),
    .reg_ctl_en (reg_ctl_en), .int_sel (int_sel), .gate_en (gate_en),
    .mod_lvl (mod_s), .mod_rise (mod_rise), .mod_recent (mod_recent),
    .last_hi (last_hi),
    .src (src), .ext_level (ext_level), .active (active)
  );

  always_ff @(posedge clk) begin
    if (rst)                      tone_out <= 1'b0;
    else if (src == SRC_EXTERNAL) tone_out <= ext_level;
    else                          tone_out <= active && phase;
  end

  AST_GATE_BLOCKS_EXT: assert property (@(posedge clk) disable iff (rst) (reg_ctl_en && !int_sel && !gate_en) |=> !tone_out) else $error("gated-off external tone leaked"); // R7
  AST_IDLE_INT_LOW: assert property (@(posedge clk) disable iff (rst) (src == SRC_INTERNAL && !active) |=> !tone_out) else $error("idle internal source drove output"); // R4
endmodule

// File: tb/tb_tone_source_sel.sv
module tb_tone_source_sel;
  localparam int unsigned CLK_HZ  = 2_640_000;
  localparam int unsigned TONE_HZ = 22_000;
  localparam int H   = CLK_HZ / (2 * TONE_HZ);
  localparam int ENV = 3 * H;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mod_in = 1'b0, reg_ctl_en = 1'b0, int_sel = 1'b0, gate_en = 1'b0;
  logic tone_out;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_source_sel #(.CLK_HZ(CLK_HZ), .TONE_HZ(TONE_HZ)) dut (
    .clk (clk), .rst (rst), .mod_in (mod_in), .reg_ctl_en (reg_ctl_en),
    .int_sel (int_sel), .gate_en (gate_en), .tone_out (tone_out)
  );

  task automatic push(input int c, input bit v, input string tag);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic at(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Monitor: compare scoreboard items as their cycle comes up.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (e.cyc < cyc || tone_out !== e.val) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: actual %0b expected %0b", e.tag, e.cyc, tone_out, e.val);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #80000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int s, c, c2, b, d, e, f, x, hi, lo, freq, duty;
    bit prev;
    @(negedge clk);
    push(2, 1'b0, "R1 in reset");
    push(6, 1'b0, "R1 after reset");
    at(4); rst = 1'b0;

    // Internal tone under gate only (R8), restart (R3), drain (R4)
    at(20); reg_ctl_en = 1'b1; int_sel = 1'b1; gate_en = 1'b1;
    s = 21;
    push(s, 1'b1, "R3 first high");
    push(s + H - 1, 1'b1, "R3 full first half");
    push(s + H, 1'b0, "R2 low half");
    push(s + 2*H - 1, 1'b0, "R2 low half end");
    push(s + 2*H, 1'b1, "R8 second period");
    push(s + 3*H - 1, 1'b1, "R4 drain high kept");
    push(s + 3*H, 1'b0, "R4 stop after high");
    push(s + 4*H, 1'b0, "R4 stays stopped");
    at(s + H + H/2); gate_en = 1'b0;
    at(s + 5*H);

    // External tone under gate (R7)
    c = cyc;
    int_sel = 1'b0; gate_en = 1'b1;
    push(c + 7, 1'b0, "R7 sync latency");
    push(c + 8, 1'b1, "R7 pass-through");
    push(c + 21, 1'b0, "R7 gate off");
    push(c + 43, 1'b0, "R7 ignored while gated");
    push(c + 45, 1'b0, "R7 ignored while gated");
    at(c + 5);  mod_in = 1'b1;
    at(c + 20); gate_en = 1'b0;
    at(c + 30); mod_in = 1'b0;
    at(c + 40); mod_in = 1'b1;
    at(c + 50); mod_in = 1'b0;

    // Automatic classification, burst (R6)
    c2 = c + 60;
    at(c2); reg_ctl_en = 1'b0; int_sel = 1'b0;
    b = c2 + 300;
    for (int k = 0; k < 6; k++) begin
      push(b + k*H + 2, (k % 2) == 1, "R6 burst prior level");
      push(b + k*H + 3, (k % 2) == 0, "R6 burst copy");
    end
    for (int k = 0; k < 6; k++) begin
      at(b + k*H); mod_in = ((k % 2) == 0);
    end

    // Automatic classification, envelope (R5)
    d = b + 5*H + 400;
    e = d + 4 + ENV;
    push(d + 3, 1'b1, "R6 envelope start passes");
    push(e - 1, 1'b1, "R6 pass-through until timeout");
    push(e + H - 1, 1'b1, "R5 internal first half");
    push(e + H, 1'b0, "R5 internal low");
    push(e + 2*H - 1, 1'b0, "R5 internal low end");
    push(e + 2*H, 1'b1, "R5 internal second period");
    push(e + 2*H + 13, 1'b0, "R6 envelope fall copied");
    at(d); mod_in = 1'b1;
    at(e + 2*H + 10); mod_in = 1'b0;

    // Envelope-gated internal tone after arming (R9), restart (R3)
    f = e + 2*H + 410;
    s = f + 1;
    x = s + 5*H;
    push(s, 1'b1, "R8 start before arming");
    push(s + 2*H, 1'b1, "R9 drain high");
    push(s + 3*H - 1, 1'b1, "R9 drain high end");
    push(s + 3*H, 1'b0, "R9 stop on envelope fall");
    push(s + 4*H, 1'b0, "R9 stays off while envelope low");
    push(x + 2, 1'b0, "R3 before restart");
    push(x + 3, 1'b1, "R3 restart high");
    push(x + 2 + H, 1'b1, "R3 restart full half");
    push(x + 3 + H, 1'b0, "R3 restart low");
    at(f); reg_ctl_en = 1'b1; int_sel = 1'b1; gate_en = 1'b1; mod_in = 1'b0;
    at(s + 5);     mod_in = 1'b1;
    at(s + H + 10); mod_in = 1'b0;
    at(x);         mod_in = 1'b1;
    at(x + 3*H);   gate_en = 1'b0;

    // Period and duty measurement (R2)
    at(x + 6*H); gate_en = 1'b1;
    prev = tone_out;
    @(negedge clk);
    while (!(prev == 1'b0 && tone_out == 1'b1)) begin
      prev = tone_out;
      @(negedge clk);
    end
    hi = 0; lo = 0;
    while (tone_out == 1'b1) begin hi++; @(negedge clk); end
    while (tone_out == 1'b0) begin lo++; @(negedge clk); end
    freq = int'(CLK_HZ) / (hi + lo);
    duty = (hi * 100) / (hi + lo);
    check(freq >= 20000 && freq <= 24000, "R2 frequency Hz", freq, 22000);
    check(duty >= 45 && duty <= 55, "R2 duty percent", duty, 50);
    check(hi == H, "R2 high half cycles", hi, H);
    check(lo == H, "R2 low half cycles", lo, H);

    gate_en = 1'b0;
    repeat (4 * H) @(negedge clk);
    check(q.size() == 0, "R1 scoreboard drained", q.size(), 0);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule